// File: doc/BRIEF.md
# NAND Ready Wait Monitor

This block decides when a NAND flash device has finished an operation. The controller fires a one-cycle `start` after it has sent the command and address cycles. The block then does four things in turn. It waits a short fixed settling time so the device has time to raise its busy indication. It waits for readiness. It reads one last status byte. Finally it reports that byte together with a timeout flag and a warning flag.

Readiness is found in one of two ways, chosen with each start. When the board wires up the busy line, the block watches the active-low busy input through a synchronizer. When the line is absent, the block reads status bytes over a simple request/acknowledge byte-read port until the ready bit is set. A separate flag marks a wait that follows a device reset on a board without the busy line. That wait first inserts the chip delay and then polls under a shorter timeout. All delays come from a clock-frequency parameter.

Top module: `nand_rdy_wait`

## Requirements
- R1: After reset, `done`, `timed_out`, `warn`, `stat_req` and `status_o` are all 0.
- R2: A `start` seen in idle begins a wait. For a settling time of ceil(SETTLE_NS × CLK_HZ / 1e9) cycles, with a minimum of 1 (100 ns by default), no status read is requested and the busy input is not evaluated. With the line already ready, the single status read is requested in the cycle after the settling time.
- R3: In pin mode (`use_pin`=1), `busy_n` passes through a 2-flop synchronizer and the block waits for it to read high (1 = ready, 0 = busy). It then makes exactly one status read and pulses `done` in the cycle that read is acknowledged.
- R4: In poll mode (`use_pin`=0), the block repeats status reads, one every two cycles when acknowledged at once, until a returned byte has bit 6 (mask 0x40) set. It then makes one final status read. `stat_cmd` is 1 on the first read of each wait and 0 on every later one.
- R5: When `after_reset`=1 and `use_pin`=0, a chip delay of CHIP_DELAY_US (default 20 us) is added after the settling time before the first read. The timeout is then RESET_TIMEOUT_MS (default 250 ms).
- R6: The timeout is counted in whole milliseconds from the end of the delays. The limit is TIMEOUT_MS (default 400 ms) in every case except R5. On expiry the block stops waiting and makes the final read. `timed_out` is set together with `done` when the wait ended by expiry. It stays set until the next accepted `start`, which clears it.
- R7: `status_o` carries the final status byte from `done` until the next `done`. `warn` is set with `done` if bit 6 of that byte is clear, and is cleared by the next accepted `start`.
- R8: `done` is high for exactly one cycle per wait.
- R9: A `start` that arrives while a wait is in progress has no effect on the wait or its outcome.
- R10: `stat_req` stays high until `stat_ack` is sampled high. Each acknowledged cycle completes one read, with `stat_data` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a wait (one-cycle pulse) |
| use_pin | input | 1 | 1 = watch busy line, 0 = poll status bytes |
| after_reset | input | 1 | Wait follows a device reset command |
| busy_n | input | 1 | Asynchronous ready/busy line, low = busy |
| stat_req | output | 1 | Status byte read request |
| stat_cmd | output | 1 | Request must first send the status command |
| stat_ack | input | 1 | Read completed, `stat_data` valid |
| stat_data | input | 8 | Status byte returned by the read port |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | Last wait ended by timeout |
| warn | output | 1 | Final status byte had its ready bit clear |
| status_o | output | 8 | Final status byte of the last wait |

## Verification
On every cycle the assertions check four rules. `done` never lasts two cycles. A request is never withdrawn before its acknowledge. No read is issued during the settling or chip delays. `timed_out` only rises with `done` and only falls after a `start`. The timer's millisecond count must also never pass its limit. The exact cycle of `done` is shown only by the bench's scenarios, for a line already ready, a line released late, polling that succeeds, timeouts in both modes and the post-reset path. The same holds for the number and command flag of the reads, the returned byte, and a stray `start` being ignored.

// File: rtl/nrw_pkg.sv
package nrw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_CHIP,
    ST_POLL,
    ST_FINAL
  } nrw_state_e;

  localparam int unsigned STAT_RDY_BIT = 6;

  function automatic int unsigned nrw_min1(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int unsigned nrw_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nrw_sync.sv
module nrw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nrw_dly_cnt.sv
module nrw_dly_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/nrw_ms_timer.sv
module nrw_ms_timer #(
  parameter int unsigned CYC_PER_MS = 1000,
  parameter int unsigned MS_W       = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [MS_W-1:0] limit,
  output logic            expired
);
  localparam int unsigned PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_MS - 1);

  logic [PRE_W-1:0] pre;
  logic [MS_W-1:0]  ms;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre     <= '0;
      ms      <= '0;
      expired <= 1'b0;
    end else if (!expired) begin
      if (pre == PRE_LAST) begin
        pre <= '0;
        ms  <= ms + MS_W'(1);
        if ((ms + MS_W'(1)) == limit) expired <= 1'b1;
      end else begin
        pre <= pre + PRE_W'(1);
      end
    end
  end

  // R6: the millisecond count never runs past the active limit
  assert_ms_bound_R6: assert property (@(posedge clk) disable iff (rst)
    ms <= limit);

  // R6: expiry is flagged only once the full limit has elapsed
  assert_expiry_at_limit_R6: assert property (@(posedge clk) disable iff (rst)
    expired |-> (ms == limit));
endmodule

// File: rtl/nand_rdy_wait.sv
module nand_rdy_wait
  import nrw_pkg::*;
#(
  parameter int unsigned CLK_HZ           = 200_000_000,
  parameter int unsigned SETTLE_NS        = 100,
  parameter int unsigned CHIP_DELAY_US    = 20,
  parameter int unsigned TIMEOUT_MS       = 400,
  parameter int unsigned RESET_TIMEOUT_MS = 250,
  parameter int unsigned SYNC_STAGES      = 2,
  parameter int unsigned STAT_W           = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              use_pin,
  input  logic              after_reset,
  input  logic              busy_n,
  output logic              stat_req,
  output logic              stat_cmd,
  input  logic              stat_ack,
  input  logic [STAT_W-1:0] stat_data,
  output logic              done,
  output logic              timed_out,
  output logic              warn,
  output logic [STAT_W-1:0] status_o
);
  localparam int unsigned KHZ        = CLK_HZ / 1000;
  localparam int unsigned CYC_PER_MS = nrw_min1(KHZ);
  localparam int unsigned SETTLE_CYC = nrw_min1((KHZ * SETTLE_NS + 999_999) / 1_000_000);
  localparam int unsigned CHIP_CYC   = nrw_min1((KHZ * CHIP_DELAY_US) / 1000);
  localparam int unsigned DLY_W      = $clog2(nrw_max(SETTLE_CYC, CHIP_CYC) + 1);
  localparam int unsigned MS_W       = $clog2(nrw_max(TIMEOUT_MS, RESET_TIMEOUT_MS) + 1);
  localparam logic [DLY_W-1:0] SETTLE_LD = DLY_W'(SETTLE_CYC - 1);
  localparam logic [DLY_W-1:0] CHIP_LD   = DLY_W'(CHIP_CYC - 1);

  nrw_state_e state;
  logic mode_pin, mode_rst, first_rd, exit_tmo;
  logic pin_rdy, dly_zero, dly_load, expired, timer_clr;
  logic [DLY_W-1:0] dly_val;
  logic [MS_W-1:0]  ms_limit;
  logic start_ok, chip_path, stat_ready;

  assign start_ok   = (state == ST_IDLE) && start;
  assign chip_path  = mode_rst && !mode_pin;
  assign stat_ready = stat_data[STAT_RDY_BIT];
  assign dly_load   = start_ok || (state == ST_SETTLE && dly_zero && chip_path);
  assign dly_val    = start_ok ? SETTLE_LD : CHIP_LD;
  assign timer_clr  = (state != ST_POLL);
  assign ms_limit   = chip_path ? MS_W'(RESET_TIMEOUT_MS) : MS_W'(TIMEOUT_MS);

  nrw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(busy_n), .q(pin_rdy)
  );

  nrw_dly_cnt #(.W(DLY_W)) u_dly (
    .clk(clk), .rst(rst), .load(dly_load), .load_val(dly_val), .zero(dly_zero)
  );

  nrw_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MS_W(MS_W)) u_timer (
    .clk(clk), .rst(rst), .clr(timer_clr), .limit(ms_limit), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mode_pin  <= 1'b0;
      mode_rst  <= 1'b0;
      first_rd  <= 1'b0;
      exit_tmo  <= 1'b0;
      stat_req  <= 1'b0;
      stat_cmd  <= 1'b0;
      done      <= 1'b0;
      timed_out <= 1'b0;
      warn      <= 1'b0;
      status_o  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_SETTLE;
            mode_pin  <= use_pin;
            mode_rst  <= after_reset;
            first_rd  <= 1'b1;
            exit_tmo  <= 1'b0;
            timed_out <= 1'b0;
            warn      <= 1'b0;
          end
        end
        ST_SETTLE: begin
          if (dly_zero) state <= chip_path ? ST_CHIP : ST_POLL;
        end
        ST_CHIP: begin
          if (dly_zero) state <= ST_POLL;
        end
        ST_POLL: begin
          if (mode_pin) begin
            if (pin_rdy || expired) begin
              state    <= ST_FINAL;
              stat_req <= 1'b1;
              stat_cmd <= first_rd;
              first_rd <= 1'b0;
              exit_tmo <= !pin_rdy;
            end
          end else if (!stat_req) begin
            stat_req <= 1'b1;
            stat_cmd <= first_rd;
            first_rd <= 1'b0;
          end else if (stat_ack) begin
            if (stat_ready || expired) begin
              state    <= ST_FINAL;
              stat_cmd <= 1'b0;
              exit_tmo <= !stat_ready;
            end else begin
              stat_req <= 1'b0;
            end
          end
        end
        ST_FINAL: begin
          if (stat_ack) begin
            stat_req  <= 1'b0;
            status_o  <= stat_data;
            warn      <= !stat_ready;
            timed_out <= exit_tmo;
            done      <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: a pending read is never withdrawn before its acknowledge
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (stat_req && !stat_ack) |=> stat_req);

  // R2 and R5: nothing is read while a settling or chip delay runs
  assert_quiet_delay_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETTLE || state == ST_CHIP) |-> !stat_req);

  // R6: the timeout flag rises only together with completion
  assert_tmo_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(timed_out) |-> done);

  // R6: the timeout flag is cleared only by a new start
  assert_tmo_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(timed_out) |-> $past(start));
endmodule

// File: tb/nand_rdy_wait_tb.sv
`timescale 1ns/1ps
module nand_rdy_wait_tb;
  localparam int S_CYC = 1;     // 100 ns at 1 MHz, minimum one cycle
  localparam int CH    = 20;    // 20 us at 1 MHz
  localparam int LM    = 4000;  // 4 ms timeout
  localparam int LMR   = 2000;  // 2 ms post-reset timeout

  logic clk = 1'b0, rst = 1'b1;
  logic start = 1'b0, use_pin = 1'b0, after_reset = 1'b0, busy_n = 1'b0;
  logic stat_req, stat_cmd, stat_ack = 1'b0;
  logic [7:0] stat_data = 8'h00;
  logic done, timed_out, warn;
  logic [7:0] status_o;

  nand_rdy_wait #(.CLK_HZ(1_000_000), .TIMEOUT_MS(4), .RESET_TIMEOUT_MS(2)) u_dut (
    .clk(clk), .rst(rst), .start(start), .use_pin(use_pin), .after_reset(after_reset),
    .busy_n(busy_n), .stat_req(stat_req), .stat_cmd(stat_cmd), .stat_ack(stat_ack),
    .stat_data(stat_data), .done(done), .timed_out(timed_out), .warn(warn),
    .status_o(status_o)
  );

  always #2.5 clk = ~clk;

  int cyc = 0, t0 = -100, exp_done = -100, rdy_after = 1, rd_cnt = 0, first_rd_cyc = -1;
  int compared = 0, mism = 0;
  logic exp_tmo = 0, exp_warn = 0, p_tmo = 0, p_warn = 0;
  logic [7:0] exp_status = 8'h00, p_status = 8'h00;
  string tag_s = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic fail(input string r, input string what, input int act, input int exp);
    mism++;
    $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", r, what, act, exp, cyc);
  endtask

  // Status read responder: acknowledges at once, ready bit set from read rdy_after on
  always @(negedge clk) begin
    if (stat_req) begin
      rd_cnt++;
      if (rd_cnt == 1) first_rd_cyc = cyc;
      compared++;
      if (stat_cmd !== (rd_cnt == 1)) fail("R4", "stat_cmd", stat_cmd, (rd_cnt == 1));
      stat_ack  = 1'b1;
      stat_data = {1'b1, (rd_cnt >= rdy_after), 6'(rd_cnt)};
    end else begin
      stat_ack = 1'b0;
    end
  end

  // Reference model and per-cycle comparison
  always @(negedge clk) begin
    if (cyc == t0) begin exp_tmo = 0; exp_warn = 0; end
    if (cyc == exp_done) begin exp_tmo = p_tmo; exp_warn = p_warn; exp_status = p_status; end
    compared++;
    if (done !== (cyc == exp_done)) fail(rst ? "R1" : tag_s, "done R8", done, (cyc == exp_done));
    if (timed_out !== exp_tmo) fail(rst ? "R1" : "R6", "timed_out", timed_out, exp_tmo);
    if (warn !== exp_warn) fail(rst ? "R1" : "R7", "warn", warn, exp_warn);
    if (status_o !== exp_status) fail(rst ? "R1" : "R7", "status_o", status_o, exp_status);
    if (rst && stat_req !== 1'b0) fail("R1", "stat_req", stat_req, 0);
  end

  // busy_mode: 0 line ready, 1 released 50 cycles after start, 2 stuck busy
  task automatic run(input bit pin, input bit rs, input int busy_mode, input int rdy_i,
                     input int d, input int reads, input bit rdy_fin, input bit tmo,
                     input string tg, input int first_off, input int ign_at);
    @(negedge clk);
    busy_n = (busy_mode == 0);
    rdy_after = rdy_i;
    repeat (4) @(negedge clk);
    rd_cnt = 0; first_rd_cyc = -1;
    use_pin = pin; after_reset = rs; tag_s = tg;
    t0 = cyc + 1; exp_done = t0 + d;
    p_tmo = tmo; p_warn = !rdy_fin; p_status = {1'b1, rdy_fin, 6'(reads)};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (cyc < exp_done + 3) begin
      @(negedge clk);
      if (busy_mode == 1 && cyc == t0 + 50) busy_n = 1'b1;
      start = (ign_at >= 0 && cyc == t0 + ign_at);
    end
    compared++;
    if (rd_cnt != reads) fail({tg, " R4/R10"}, "read count", rd_cnt, reads);
    if (first_off >= 0) begin
      compared++;
      if (first_rd_cyc != t0 + first_off)
        fail(rs ? "R5" : "R2", "first read cycle", first_rd_cyc - t0, first_off);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    run(1, 0, 0, 1, S_CYC + 2, 1, 1, 0, "R3", S_CYC + 1, -1);             // line ready
    run(1, 0, 1, 1, 50 + 4, 1, 1, 0, "R9", -1, 20);                       // late release, stray start
    run(0, 0, 0, 3, S_CYC + 2 * 3 + 1, 4, 1, 0, "R4", S_CYC + 1, -1);     // ready on third poll
    run(0, 0, 0, 100000, S_CYC + LM + 3, LM / 2 + 2, 0, 1, "R6", S_CYC + 1, -1);
    run(1, 0, 2, 1, S_CYC + LM + 2, 1, 1, 1, "R6", -1, -1);               // pin timeout
    run(0, 1, 0, 1, S_CYC + CH + 3, 2, 1, 0, "R5", S_CYC + CH + 1, -1);   // after reset
    run(0, 1, 0, 100000, S_CYC + CH + LMR + 3, LMR / 2 + 2, 0, 1, "R5", S_CYC + CH + 1, -1);
    run(1, 0, 0, 1, S_CYC + 2, 1, 1, 0, "R7", S_CYC + 1, -1);             // flags cleared
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mism++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end
endmodule